// File: doc/BRIEF.md
# RDS Block Syndrome Detector

This block takes a serial RDS bit stream together with its bit clock and a per-bit quality indication. The bit clock is asynchronous to the system clock. The block keeps the 26 most recent data bits and their quality bits in two shift registers that move together. After every rising bit-clock edge it divides the stored 26-bit word by the RDS generator polynomial, one bit per system clock. It then compares the 10-bit remainder with the offset syndromes of the block types.

A match raises a sticky valid flag and a one-cycle pulse, and the block reports a 3-bit code for the matched block type. The block-E syndrome used for radio paging counts only when a paging enable input is high. The quality register drives two flags: one for a single correctable error region of one or two adjacent bits, and one for every other pattern that contains bad bits.

For error correction done by software, both registers can be written directly. A syndrome calculation can also be started without a bit clock edge, so software can recheck a word it has edited. Correcting the bits is left to software.

Top module: `rds_sync_detect`

## Requirements
- R1: On each rising edge of `rds_clk_i` the block samples `rds_dat_i` into bit 0 of the data register, and the older bits move one place toward bit 25. It samples `rds_qual_i` into bit 0 of the quality register in the same way. Both inputs pass through a two-flop synchronizer. The new contents appear at `data_o` and `qual_o` within 4 system clocks of the edge.
- R2: Each rising bit-clock edge starts a syndrome calculation on the updated word. The syndrome is the remainder of the 26-bit word, with bit 25 as the highest power, divided by x^10+x^8+x^7+x^5+x^4+x^3+1. `busy_o` is high for exactly 26 system clocks per calculation. A new start while a calculation is running restarts it.
- R3: When a calculation ends, `blk_code_o` takes the code of the matched syndrome: 0x3D8 gives 0, 0x3D4 gives 1, 0x25C gives 2, 0x3CC gives 3 and 0x258 gives 4.
- R4: Syndrome 0x000 gives code 5 only while `paging_en_i` is 1. While `paging_en_i` is 0 it counts as no match.
- R5: A calculation with no match sets `blk_code_o` to 7. It leaves `valid_o` unchanged and produces no pulse.
- R6: A match sets `valid_o` and pulses `valid_pulse_o` for one cycle. `valid_o` then stays 1 until `clr_valid_i` is 1 on a clock edge. If a match and a clear happen on the same edge, the match wins.
- R7: A quality bit of 1 marks the data bit as unreliable. `sqe_o` is 1 exactly when the quality register holds either one set bit or two set bits in adjacent positions.
- R8: `mqe_o` is 1 when the quality register holds any set bit and `sqe_o` is 0. The two flags are never high together.
- R9: `sw_load_i` writes `sw_data_i` and `sw_qual_i` into the two registers and does not start a calculation by itself. If a bit-clock edge arrives in the same cycle, the write takes precedence. `sw_start_i` starts a calculation on the contents the data register holds after that cycle.
- R10: After reset both registers are 0, `blk_code_o` is 7, and `busy_o`, `valid_o`, `valid_pulse_o`, `sqe_o` and `mqe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rds_clk_i | input | 1 | RDS bit clock, asynchronous |
| rds_dat_i | input | 1 | RDS data bit |
| rds_qual_i | input | 1 | Quality of the data bit, 1 = unreliable |
| paging_en_i | input | 1 | Enables the block-E paging syndrome |
| sw_load_i | input | 1 | Writes both registers from software |
| sw_data_i | input | 26 | Data word to write |
| sw_qual_i | input | 26 | Quality word to write |
| sw_start_i | input | 1 | Starts a calculation without a bit edge |
| clr_valid_i | input | 1 | Clears the valid flag |
| data_o | output | 26 | Data register |
| qual_o | output | 26 | Quality register |
| busy_o | output | 1 | Calculation in progress |
| blk_code_o | output | 3 | Block code of the last calculation |
| valid_o | output | 1 | Sticky valid-syndrome flag |
| valid_pulse_o | output | 1 | One-cycle valid-syndrome pulse |
| sqe_o | output | 1 | Single quality error |
| mqe_o | output | 1 | Multiple quality error |

## Verification
The bench shifts in complete blocks of each type serially, with check words it derives from its own polynomial division. A design that shifted the wrong way, or that computed the remainder in a different bit order, would report code 7 instead of the block type. The all-zero word is checked with paging off and on: a design that ignored the enable would flag paging syndromes during normal reception. The bench also checks that a non-matching word leaves a set flag alone and produces no pulse, that the clear input resets the flag, and that a calculation lasts exactly 26 cycles. Quality patterns cover one bit at each end of the register, two adjacent bits, two separated bits and three adjacent bits, so that a design that counted bits without checking adjacency would misclassify at least one of them.

// File: rtl/rds_sync_detect.sv
module rds_sync_detect #(
  parameter int          BLK_W  = 26,
  parameter int          CHK_W  = 10,
  parameter logic [9:0]  POLY   = 10'h1B9,
  parameter logic [9:0]  SYN_A  = 10'h3D8,
  parameter logic [9:0]  SYN_B  = 10'h3D4,
  parameter logic [9:0]  SYN_C  = 10'h25C,
  parameter logic [9:0]  SYN_CP = 10'h3CC,
  parameter logic [9:0]  SYN_D  = 10'h258,
  parameter logic [9:0]  SYN_E  = 10'h000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rds_clk_i,
  input  logic             rds_dat_i,
  input  logic             rds_qual_i,
  input  logic             paging_en_i,
  input  logic             sw_load_i,
  input  logic [BLK_W-1:0] sw_data_i,
  input  logic [BLK_W-1:0] sw_qual_i,
  input  logic             sw_start_i,
  input  logic             clr_valid_i,
  output logic [BLK_W-1:0] data_o,
  output logic [BLK_W-1:0] qual_o,
  output logic             busy_o,
  output logic [2:0]       blk_code_o,
  output logic             valid_o,
  output logic             valid_pulse_o,
  output logic             sqe_o,
  output logic             mqe_o
);
  localparam int CNT_W = $clog2(BLK_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_W - 1);

  logic [2:0]       clk_s;
  logic [1:0]       dat_s, qual_s;
  logic             rise;
  logic [BLK_W-1:0] data_q, qual_q, data_nx, qual_nx, sh_q;
  logic [CHK_W-1:0] syn_q, syn_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             start;
  logic [2:0]       code_nx;
  logic             match;
  logic [5:0]       nbad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_s  <= '0;
      dat_s  <= '0;
      qual_s <= '0;
    end else begin
      clk_s  <= {clk_s[1:0], rds_clk_i};
      dat_s  <= {dat_s[0], rds_dat_i};
      qual_s <= {qual_s[0], rds_qual_i};
    end

  assign rise = clk_s[1] & ~clk_s[2];

  assign data_nx = sw_load_i ? sw_data_i : rise ? {data_q[BLK_W-2:0], dat_s[1]}  : data_q;
  assign qual_nx = sw_load_i ? sw_qual_i : rise ? {qual_q[BLK_W-2:0], qual_s[1]} : qual_q;
  assign start   = rise | sw_start_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      qual_q <= '0;
    end else begin
      data_q <= data_nx;
      qual_q <= qual_nx;
    end

  assign syn_nx = {syn_q[CHK_W-2:0], sh_q[BLK_W-1]} ^ (syn_q[CHK_W-1] ? POLY : '0);

  always_comb begin
    match   = 1'b1;
    code_nx = 3'd7;
    if      (syn_nx == SYN_A)                 code_nx = 3'd0;
    else if (syn_nx == SYN_B)                 code_nx = 3'd1;
    else if (syn_nx == SYN_C)                 code_nx = 3'd2;
    else if (syn_nx == SYN_CP)                code_nx = 3'd3;
    else if (syn_nx == SYN_D)                 code_nx = 3'd4;
    else if (syn_nx == SYN_E && paging_en_i)  code_nx = 3'd5;
    else                                      match   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q          <= '0;
      syn_q         <= '0;
      cnt_q         <= '0;
      busy_o        <= 1'b0;
      blk_code_o    <= 3'd7;
      valid_pulse_o <= 1'b0;
    end else begin
      valid_pulse_o <= 1'b0;
      if (start) begin
        sh_q   <= data_nx;
        syn_q  <= '0;
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        sh_q  <= sh_q << 1;
        syn_q <= syn_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_o        <= 1'b0;
          blk_code_o    <= code_nx;
          valid_pulse_o <= match;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              valid_o <= 1'b0;
    else if (busy_o && !start && cnt_q == LAST && match) valid_o <= 1'b1;
    else if (clr_valid_i)                    valid_o <= 1'b0;

  assign nbad  = 6'($countones(qual_q));
  assign sqe_o = (nbad == 6'd1) || (nbad == 6'd2 && (qual_q & (qual_q >> 1)) != '0);
  assign mqe_o = (nbad != 6'd0) && !sqe_o;

  assign data_o = data_q;
  assign qual_o = qual_q;

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !sw_load_i |=> data_q[BLK_W-1:1] == $past(data_q[BLK_W-2:0]) &&
                           qual_q[BLK_W-1:1] == $past(qual_q[BLK_W-2:0]));

  assert_load_no_calc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load_i && !start && !busy_o |=> !busy_o);

  assert_paging_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse_o && blk_code_o == 3'd5 |-> $past(paging_en_i));

  assert_pulse_has_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse_o |-> blk_code_o != 3'd7);

  assert_pulse_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse_o |-> valid_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_valid_i |=> valid_o);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sqe_o && mqe_o));

  assert_single_needs_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_o |-> qual_o != '0);
endmodule

// File: tb/tb_rds_sync_detect.sv
module tb_rds_sync_detect;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rds_clk = 1'b0, rds_dat = 1'b0, rds_qual = 1'b0, paging_en = 1'b0;
  logic        sw_load = 1'b0, sw_start = 1'b0, clr_valid = 1'b0;
  logic [25:0] sw_data = '0, sw_qual = '0;
  logic [25:0] data_o, qual_o;
  logic        busy, valid, vpulse, sqe, mqe;
  logic [2:0]  code;
  int n_tests = 0, n_fail = 0, n_pulse = 0;

  always #10 clk = ~clk;

  rds_sync_detect dut (
    .clk(clk), .rst_n(rst_n), .rds_clk_i(rds_clk), .rds_dat_i(rds_dat),
    .rds_qual_i(rds_qual), .paging_en_i(paging_en), .sw_load_i(sw_load),
    .sw_data_i(sw_data), .sw_qual_i(sw_qual), .sw_start_i(sw_start),
    .clr_valid_i(clr_valid), .data_o(data_o), .qual_o(qual_o), .busy_o(busy),
    .blk_code_o(code), .valid_o(valid), .valid_pulse_o(vpulse), .sqe_o(sqe), .mqe_o(mqe));

  always @(posedge clk) if (vpulse) n_pulse++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rem(input logic [25:0] w);
    logic [25:0] t = w;
    for (int i = 25; i >= 10; i--)
      if (t[i]) t = t ^ (26'h5B9 << (i - 10));
    return t[9:0];
  endfunction

  function automatic logic [25:0] mk(input logic [15:0] info, input logic [9:0] target);
    for (int c = 0; c < 1024; c++)
      if (rem({info, 10'(c)}) == target) return {info, 10'(c)};
    return '0;
  endfunction

  task automatic clear_valid();
    @(negedge clk) clr_valid = 1'b1;
    @(negedge clk) clr_valid = 1'b0;
  endtask

  task automatic send_bit(input logic d, input logic q);
    @(negedge clk) begin rds_dat = d; rds_qual = q; end
    @(negedge clk) rds_clk = 1'b1;
    repeat (32) @(negedge clk);
    rds_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sw_calc(input logic [25:0] w);
    @(negedge clk) begin sw_load = 1'b1; sw_data = w; end
    @(negedge clk) begin sw_load = 1'b0; sw_start = 1'b1; end
    @(negedge clk) sw_start = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 data", 32'(data_o), 0);
    chk("R10 qual", 32'(qual_o), 0);
    chk("R10 code", 32'(code), 7);
    chk("R10 flags", {busy, valid, vpulse, sqe, mqe}, 0);
  endtask

  task automatic t_serial(input logic [15:0] info, input logic [9:0] syn, input int exp_code,
                          input logic [25:0] q);
    logic [25:0] w = mk(info, syn);
    for (int i = 25; i >= 1; i--) send_bit(w[i], q[i]);
    clear_valid();
    send_bit(w[0], q[0]);
    chk("R1 data shifted", 32'(data_o), 32'(w));
    chk("R1 quality shifted", 32'(qual_o), 32'(q));
    chk("R3 block code", 32'(code), 32'(exp_code));
    chk("R6 valid set", 32'(valid), 1);
  endtask

  task automatic t_paging();
    int p;
    clear_valid();
    paging_en = 1'b0;
    p = n_pulse;
    sw_calc(26'h0);
    chk("R4 E ignored code", 32'(code), 7);
    chk("R4 E ignored valid", 32'(valid), 0);
    chk("R4 E ignored pulse", 32'(n_pulse - p), 0);
    paging_en = 1'b1;
    sw_calc(mk(16'h1234, 10'h000));
    chk("R4 E detected", 32'(code), 5);
    chk("R6 pulse once", 32'(n_pulse - p), 1);
    paging_en = 1'b0;
  endtask

  task automatic t_nomatch();
    int p;
    sw_calc(mk(16'hBEEF, 10'h3D4));
    chk("R6 valid after B", 32'(valid), 1);
    p = n_pulse;
    sw_calc(mk(16'hBEEF, 10'h111));
    chk("R5 no-match code", 32'(code), 7);
    chk("R5 valid kept", 32'(valid), 1);
    chk("R5 no pulse", 32'(n_pulse - p), 0);
    clear_valid();
    chk("R6 cleared", 32'(valid), 0);
    sw_calc(mk(16'h0F0F, 10'h2A5));
    chk("R5 valid stays clear", 32'(valid), 0);
  endtask

  task automatic t_busy();
    int n = 0;
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R2 busy length", 32'(n), 26);
  endtask

  task automatic t_load();
    logic [2:0] c0;
    sw_calc(mk(16'h5555, 10'h3CC));
    c0 = code;
    chk("R3 C' code", 32'(c0), 3);
    @(negedge clk) begin sw_load = 1'b1; sw_data = mk(16'hAAAA, 10'h3D8); sw_qual = '0; end
    @(negedge clk) sw_load = 1'b0;
    chk("R9 load no busy", 32'(busy), 0);
    repeat (30) @(negedge clk);
    chk("R9 load keeps code", 32'(code), 32'(c0));
    chk("R9 loaded data", 32'(data_o), 32'(mk(16'hAAAA, 10'h3D8)));
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9 start on edited word", 32'(code), 0);
  endtask

  task automatic t_qual(input logic [25:0] q, input logic es, input logic em, input string tag);
    @(negedge clk) begin sw_load = 1'b1; sw_qual = q; sw_data = data_o; end
    @(negedge clk) sw_load = 1'b0;
    chk({tag, " sqe"}, 32'(sqe), 32'(es));
    chk({tag, " mqe"}, 32'(mqe), 32'(em));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_serial(16'h8D21, 10'h3D8, 0, 26'h0);
    t_serial(16'h0408, 10'h3D4, 1, 26'h0000300);
    t_serial(16'hE5A0, 10'h25C, 2, 26'h2000000);
    t_serial(16'h7F11, 10'h258, 4, 26'h0000005);
    t_paging();
    t_nomatch();
    t_busy();
    t_load();
    t_qual(26'h0,       1'b0, 1'b0, "R7 clean");
    t_qual(26'h0000001, 1'b1, 1'b0, "R7 single low");
    t_qual(26'h2000000, 1'b1, 1'b0, "R7 single high");
    t_qual(26'h3000000, 1'b1, 1'b0, "R7 adjacent pair");
    t_qual(26'h0000005, 1'b0, 1'b1, "R8 split pair");
    t_qual(26'h0000380, 1'b0, 1'b1, "R8 triple");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule